// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

This block turns commands that software writes into a dispatch register into per-core control actions. A command holds a two-bit type, a target core number and a vector. Depending on its type, the command posts an interrupt to the target, applies a power-on reset to it, stops it, or starts it again. The block keeps a run/halt flag for every core. An interrupt post raises a per-core wake line only when the target is running, so a core that has been halted stays asleep even while interrupts are posted to it.

The number of populated cores is an input. Any command whose target number is equal to or above that count is dropped with no trace. A reset command is honoured only when its vector equals the power-on-reset code, which is set by a parameter. Any other vector on a reset command to a present core sets a sticky error flag and changes nothing else. All outputs are registered and respond in the cycle after the command is accepted. The block accepts one command per cycle.

Top module: `ipi_dispatch`

## Requirements
- R1: While reset is held and after it is released, core 0 reads running and every other core reads halted. No post, wake or reset pulse is active, and the error flag is clear.
- R2: A command of type 0 (post) to a present core raises int_post_o for exactly one cycle, starting the cycle after acceptance. In that cycle int_cpu_o and int_vec_o carry the command's target and vector.
- R3: With a post, wake_o carries a single bit at the target's position, and only when the target was running. A post to a halted core still pulses int_post_o but leaves wake_o all zero.
- R4: A command of type 1 (reset) whose vector equals POR_VEC (default 6'h01) gives a one-cycle pulse on rst_pulse_o at the target's bit and marks the target running, both in the cycle after acceptance.
- R5: A type 1 command to a present core with any other vector sets reset_err_o. The flag stays set until reset. The command produces no reset pulse and no change to run state.
- R6: A command of type 2 (idle) clears the target's running bit. Later posts to that core do not wake it.
- R7: A command of type 3 (resume) sets the target's running bit.
- R8: A command whose target number is not below cpu_count_i has no effect at all: no post, no wake, no pulse, no run-state change and no error. A target of cpu_count_i-1 is still accepted.
- R9: Inputs presented while cmd_valid_i is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_count_i | input | CPU_W+1 | Number of populated cores |
| cmd_valid_i | input | 1 | Dispatch register write strobe |
| cmd_type_i | input | 2 | 0 post, 1 reset, 2 idle, 3 resume |
| cmd_cpu_i | input | CPU_W | Target core number |
| cmd_vec_i | input | VEC_W | Interrupt vector or reset code |
| int_post_o | output | 1 | One-cycle interrupt post strobe |
| int_cpu_o | output | CPU_W | Target of the current post |
| int_vec_o | output | VEC_W | Vector of the current post |
| wake_o | output | NUM_CPU | Per-core wake, masked by run state |
| rst_pulse_o | output | NUM_CPU | Per-core power-on reset pulse |
| running_o | output | NUM_CPU | Per-core run state |
| reset_err_o | output | 1 | Sticky flag for a reset command with a bad vector |

## Verification
The bench posts to a core that is halted at reset, and to a core it has idled, and expects the strobe to fire with no wake. A design that fails to mask the post would wake a sleeping core. Reset commands are sent with a wrong vector and then with the right one. This catches a design that resets on any vector, or one whose error flag clears itself. Targets at cpu_count_i, just above it and just below it check the range test: an off-by-one comparison would either drop the last valid core or act on a missing one. Each strobe is also checked one cycle later to expose pulses that last longer than one cycle.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [1:0] {
    CMD_POST   = 2'd0,
    CMD_RESET  = 2'd1,
    CMD_IDLE   = 2'd2,
    CMD_RESUME = 2'd3
  } ipi_cmd_e;

  typedef struct packed {
    logic post;
    logic rst_ok;
    logic rst_bad;
    logic idle;
    logic resume;
  } ipi_act_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned VEC_W   = 6,
  parameter logic [VEC_W-1:0] POR_VEC = 6'h01,
  localparam int unsigned CPU_W  = $clog2(NUM_CPU)
) (
  input  logic               valid_i,
  input  logic [1:0]         type_i,
  input  logic [CPU_W-1:0]   cpu_i,
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [CPU_W:0]     count_i,
  output ipi_act_t           act_o,
  output logic [NUM_CPU-1:0] sel_o
);
  logic     present;
  ipi_cmd_e kind;

  assign kind    = ipi_cmd_e'(type_i);
  assign present = valid_i && ({1'b0, cpu_i} < count_i);

  always_comb begin
    act_o = '0;
    if (present) begin
      unique case (kind)
        CMD_POST:   act_o.post    = 1'b1;
        CMD_RESET:  begin
          act_o.rst_ok  = (vec_i == POR_VEC);
          act_o.rst_bad = (vec_i != POR_VEC);
        end
        CMD_IDLE:   act_o.idle    = 1'b1;
        CMD_RESUME: act_o.resume  = 1'b1;
        default:    act_o = '0;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_sel
    assign sel_o[i] = present && (cpu_i == CPU_W'(i));
  end
endmodule

// File: rtl/ipi_run_ctl.sv
module ipi_run_ctl
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ipi_act_t           act_i,
  input  logic [NUM_CPU-1:0] sel_i,
  output logic [NUM_CPU-1:0] running_o,
  output logic [NUM_CPU-1:0] rst_pulse_o
);
  for (genvar i = 0; i < NUM_CPU; i++) begin : g_core
    localparam logic RUN_INIT = (i == 0);
    logic run_q, pulse_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_q   <= RUN_INIT;
        pulse_q <= 1'b0;
      end else begin
        pulse_q <= sel_i[i] && act_i.rst_ok;
        if (sel_i[i] && (act_i.rst_ok || act_i.resume)) run_q <= 1'b1;
        else if (sel_i[i] && act_i.idle)                 run_q <= 1'b0;
      end
    end

    assign running_o[i]   = run_q;
    assign rst_pulse_o[i] = pulse_q;
  end
endmodule

// File: rtl/ipi_post_stage.sv
module ipi_post_stage
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned VEC_W   = 6,
  localparam int unsigned CPU_W  = $clog2(NUM_CPU)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ipi_act_t           act_i,
  input  logic [NUM_CPU-1:0] sel_i,
  input  logic [CPU_W-1:0]   cpu_i,
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [NUM_CPU-1:0] running_i,
  output logic               post_o,
  output logic [CPU_W-1:0]   cpu_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [NUM_CPU-1:0] wake_o,
  output logic               err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      post_o <= 1'b0;
      cpu_o  <= '0;
      vec_o  <= '0;
      wake_o <= '0;
      err_o  <= 1'b0;
    end else begin
      post_o <= act_i.post;
      // run state sampled before this command's own update
      wake_o <= act_i.post ? (sel_i & running_i) : '0;
      if (act_i.post) begin
        cpu_o <= cpu_i;
        vec_o <= vec_i;
      end
      if (act_i.rst_bad) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned VEC_W   = 6,
  parameter logic [VEC_W-1:0] POR_VEC = 6'h01,
  localparam int unsigned CPU_W  = $clog2(NUM_CPU)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CPU_W:0]     cpu_count_i,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_type_i,
  input  logic [CPU_W-1:0]   cmd_cpu_i,
  input  logic [VEC_W-1:0]   cmd_vec_i,
  output logic               int_post_o,
  output logic [CPU_W-1:0]   int_cpu_o,
  output logic [VEC_W-1:0]   int_vec_o,
  output logic [NUM_CPU-1:0] wake_o,
  output logic [NUM_CPU-1:0] rst_pulse_o,
  output logic [NUM_CPU-1:0] running_o,
  output logic               reset_err_o
);
  ipi_act_t           act;
  logic [NUM_CPU-1:0] sel;

  ipi_cmd_decode #(.NUM_CPU(NUM_CPU), .VEC_W(VEC_W), .POR_VEC(POR_VEC)) u_dec (
    .valid_i (cmd_valid_i),
    .type_i  (cmd_type_i),
    .cpu_i   (cmd_cpu_i),
    .vec_i   (cmd_vec_i),
    .count_i (cpu_count_i),
    .act_o   (act),
    .sel_o   (sel)
  );

  ipi_run_ctl #(.NUM_CPU(NUM_CPU)) u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act),
    .sel_i       (sel),
    .running_o   (running_o),
    .rst_pulse_o (rst_pulse_o)
  );

  ipi_post_stage #(.NUM_CPU(NUM_CPU), .VEC_W(VEC_W)) u_post (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act),
    .sel_i     (sel),
    .cpu_i     (cmd_cpu_i),
    .vec_i     (cmd_vec_i),
    .running_i (running_o),
    .post_o    (int_post_o),
    .cpu_o     (int_cpu_o),
    .vec_o     (int_vec_o),
    .wake_o    (wake_o),
    .err_o     (reset_err_o)
  );
endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk #(
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned VEC_W   = 6,
  parameter logic [VEC_W-1:0] POR_VEC = 6'h01,
  localparam int unsigned CPU_W  = $clog2(NUM_CPU)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [CPU_W:0]     cpu_count_i,
  input logic               cmd_valid_i,
  input logic [1:0]         cmd_type_i,
  input logic [CPU_W-1:0]   cmd_cpu_i,
  input logic [VEC_W-1:0]   cmd_vec_i,
  input logic               int_post_o,
  input logic [CPU_W-1:0]   int_cpu_o,
  input logic [VEC_W-1:0]   int_vec_o,
  input logic [NUM_CPU-1:0] wake_o,
  input logic [NUM_CPU-1:0] rst_pulse_o,
  input logic [NUM_CPU-1:0] running_o,
  input logic               reset_err_o
);
  logic in_range;
  assign in_range = {1'b0, cmd_cpu_i} < cpu_count_i;

  assert_post_fields_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && in_range && cmd_type_i == 2'd0 |=>
      int_post_o && int_vec_o == $past(cmd_vec_i) && int_cpu_o == $past(cmd_cpu_i));

  assert_wake_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wake_o) && ((|wake_o) -> int_post_o));

  assert_wake_needs_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && in_range && cmd_type_i == 2'd0 && !running_o[cmd_cpu_i] |=> wake_o == '0);

  assert_por_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && in_range && cmd_type_i == 2'd1 && cmd_vec_i == POR_VEC |=>
      rst_pulse_o[$past(cmd_cpu_i)] && running_o[$past(cmd_cpu_i)]);

  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reset_err_o) |-> reset_err_o);

  assert_bad_rst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && in_range && cmd_type_i == 2'd1 && cmd_vec_i != POR_VEC |=>
      reset_err_o && rst_pulse_o == '0 && $stable(running_o));

  assert_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && in_range && cmd_type_i == 2'd2 |=> !running_o[$past(cmd_cpu_i)]);

  assert_resume_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && in_range && cmd_type_i == 2'd3 |=> running_o[$past(cmd_cpu_i)]);

  assert_absent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !in_range |=>
      !int_post_o && rst_pulse_o == '0 && $stable(running_o) && $stable(reset_err_o));

  assert_idle_input_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !int_post_o && rst_pulse_o == '0 && $stable(running_o));
endmodule

bind ipi_dispatch ipi_dispatch_chk #(.NUM_CPU(NUM_CPU), .VEC_W(VEC_W), .POR_VEC(POR_VEC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_count_i (cpu_count_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_type_i  (cmd_type_i),
  .cmd_cpu_i   (cmd_cpu_i),
  .cmd_vec_i   (cmd_vec_i),
  .int_post_o  (int_post_o),
  .int_cpu_o   (int_cpu_o),
  .int_vec_o   (int_vec_o),
  .wake_o      (wake_o),
  .rst_pulse_o (rst_pulse_o),
  .running_o   (running_o),
  .reset_err_o (reset_err_o)
);

// File: tb/ipi_dispatch_tb.sv
`timescale 1ns/1ps
module ipi_dispatch_tb_top;
  localparam int NUM_CPU = 8;
  localparam int VEC_W   = 6;
  localparam int CPU_W   = 3;

  typedef struct packed {
    logic [1:0] t;
    logic [2:0] cpu;
    logic [5:0] vec;
    logic       post;
    logic       wake;
    logic [7:0] rst;
    logic [7:0] run;
    logic       err;
    logic [3:0] req;
  } row_t;

  // cpu_count_i = 4 for the whole table
  localparam int NROW = 13;
  localparam row_t TBL [NROW] = '{
    '{2'd0, 3'd0, 6'd5,  1'b1, 1'b1, 8'h00, 8'h01, 1'b0, 4'd2},
    '{2'd0, 3'd1, 6'd9,  1'b1, 1'b0, 8'h00, 8'h01, 1'b0, 4'd3},
    '{2'd1, 3'd1, 6'd1,  1'b0, 1'b0, 8'h02, 8'h03, 1'b0, 4'd4},
    '{2'd0, 3'd1, 6'd10, 1'b1, 1'b1, 8'h00, 8'h03, 1'b0, 4'd3},
    '{2'd2, 3'd0, 6'd0,  1'b0, 1'b0, 8'h00, 8'h02, 1'b0, 4'd6},
    '{2'd0, 3'd0, 6'd3,  1'b1, 1'b0, 8'h00, 8'h02, 1'b0, 4'd6},
    '{2'd3, 3'd0, 6'd0,  1'b0, 1'b0, 8'h00, 8'h03, 1'b0, 4'd7},
    '{2'd0, 3'd5, 6'd7,  1'b0, 1'b0, 8'h00, 8'h03, 1'b0, 4'd8},
    '{2'd1, 3'd4, 6'd1,  1'b0, 1'b0, 8'h00, 8'h03, 1'b0, 4'd8},
    '{2'd3, 3'd6, 6'd0,  1'b0, 1'b0, 8'h00, 8'h03, 1'b0, 4'd8},
    '{2'd1, 3'd2, 6'd2,  1'b0, 1'b0, 8'h00, 8'h03, 1'b1, 4'd5},
    '{2'd1, 3'd2, 6'd1,  1'b0, 1'b0, 8'h04, 8'h07, 1'b1, 4'd4},
    '{2'd2, 3'd2, 6'd0,  1'b0, 1'b0, 8'h00, 8'h03, 1'b1, 4'd6}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [CPU_W:0]     count = 4'd4;
  logic               valid = 1'b0;
  logic [1:0]         ctype = '0;
  logic [CPU_W-1:0]   ccpu = '0;
  logic [VEC_W-1:0]   cvec = '0;
  logic               post;
  logic [CPU_W-1:0]   pcpu;
  logic [VEC_W-1:0]   pvec;
  logic [NUM_CPU-1:0] wake, rpulse, run;
  logic               err;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  ipi_dispatch #(.NUM_CPU(NUM_CPU), .VEC_W(VEC_W), .POR_VEC(6'h01)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_count_i(count), .cmd_valid_i(valid),
    .cmd_type_i(ctype), .cmd_cpu_i(ccpu), .cmd_vec_i(cvec),
    .int_post_o(post), .int_cpu_o(pcpu), .int_vec_o(pvec), .wake_o(wake),
    .rst_pulse_o(rpulse), .running_o(run), .reset_err_o(err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, result visible at the following negedge
  task automatic issue(input logic [1:0] t, input logic [2:0] c, input logic [5:0] v);
    @(negedge clk);
    valid = 1'b1; ctype = t; ccpu = c; cvec = v;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic idle_state(input string req, input logic [7:0] exp_run, input logic exp_err);
    chk(req, "post", 32'(post), 32'd0);
    chk(req, "wake", 32'(wake), 32'd0);
    chk(req, "rst_pulse", 32'(rpulse), 32'd0);
    chk(req, "running", 32'(run), 32'(exp_run));
    chk(req, "err", 32'(err), 32'(exp_err));
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12;
    idle_state("R1 in reset", 8'h01, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    idle_state("R1 after reset", 8'h01, 1'b0);

    for (int k = 0; k < NROW; k++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", TBL[k].req, k);
      issue(TBL[k].t, TBL[k].cpu, TBL[k].vec);
      chk(tag, "post", 32'(post), 32'(TBL[k].post));
      chk(tag, "wake", 32'(wake), TBL[k].wake ? (32'd1 << TBL[k].cpu) : 32'd0);
      chk(tag, "rst_pulse", 32'(rpulse), 32'(TBL[k].rst));
      chk(tag, "running", 32'(run), 32'(TBL[k].run));
      chk(tag, "err", 32'(err), 32'(TBL[k].err));
      if (TBL[k].post) begin
        chk(tag, "int_cpu", 32'(pcpu), 32'(TBL[k].cpu));
        chk(tag, "int_vec", 32'(pvec), 32'(TBL[k].vec));
      end
      @(negedge clk);
      // R2 R4: strobes last one cycle
      chk("R2 R4 strobe width", "post|rst", 32'({post, rpulse}), 32'd0);
    end

    // R9: inputs without valid ignored
    @(negedge clk);
    ctype = 2'd1; ccpu = 3'd3; cvec = 6'h01;
    @(negedge clk);
    @(negedge clk);
    idle_state("R9 no valid", 8'h03, 1'b1);

    // R8 boundary: cpu 7 with count 7 dropped, with count 8 accepted
    count = 4'd7;
    issue(2'd3, 3'd7, 6'd0);
    idle_state("R8 cpu==count", 8'h03, 1'b1);
    count = 4'd8;
    issue(2'd3, 3'd7, 6'd0);
    chk("R8 cpu==count-1", "running", 32'(run), 32'h83);

    // R5: error on absent core does not matter; sticky until reset
    count = 4'd2;
    rst_n = 1'b0;
    @(negedge clk);
    idle_state("R1 re-reset", 8'h01, 1'b0);
    rst_n = 1'b1;
    issue(2'd1, 3'd3, 6'd9);
    idle_state("R8 bad reset to absent core", 8'h01, 1'b0);
    issue(2'd1, 3'd1, 6'd0);
    chk("R5 bad vec 0", "err", 32'(err), 32'd1);
    chk("R5 bad vec 0", "running", 32'(run), 32'h01);
    issue(2'd0, 3'd0, 6'd63);
    chk("R5 sticky", "err", 32'(err), 32'd1);
    chk("R2 vec max", "int_vec", 32'(pvec), 32'd63);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule